// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Port

This block is a cut-down boundary-scan test port for a memory device. A serial test clock, a mode-select line, a serial data input and a serial data output drive the standard sixteen-state test controller. The port has no dedicated test-reset pin. The controller reaches its reset state either through the chip-level synchronous reset `rst` or by holding the mode-select line high.

Three data registers sit behind a three-bit instruction register:
- a one-bit bypass cell;
- a 32-bit identification word;
- a 70-cell boundary register that samples the device pads from a parallel input.

The port only captures pad values and never drives the pads. It does raise `pads_hiz`, which tells the device to float every data driver while a sample-with-tristate instruction is active. Serial output changes on the falling test-clock edge. The output is enabled only while a register is being shifted.

Top module: `tap_lite`

## Requirements
- R1: The controller follows the standard sixteen-state test-port diagram, advancing on each rising edge of `tck` according to `tms`. Exit1 → Pause → Exit2 → Shift resumes shifting the same register contents without capturing them again.
- R2: Five consecutive rising `tck` edges with `tms` high reach Test-Logic-Reset from any state. Reaching it selects the identification instruction and clears `pads_hiz`.
- R3: On Capture-IR the instruction shifter loads binary 001. It shifts out least-significant bit first, so the first three bits seen on `tdo` are 1, 0, 0.
- R4: The instruction (loaded through Shift-IR, least-significant bit first, applied in Update-IR) selects a data register. Codes 000, 010 and 100 select the boundary register, 001 selects the identification register, and 011, 101, 110 and 111 select the bypass cell.
- R5: The identification word, read least-significant bit first, holds these fields: bit 0 = 1; bits 11:1 = 00000000111; bits 17:12 = the `ID_VDEF` parameter; bits 27:18 = 0100000100; bits 31:28 = 0000.
- R6: The bypass cell captures 0 in Capture-DR. It delays `tdi` by one shift.
- R7: The boundary register is `BSR_LEN` (70) cells long. In Capture-DR it loads `pad_sample`, except that cells set in `PH_MASK` load 0. Cell 0 (`pad_sample[0]`) is the first bit out, and `tdi` reappears after `BSR_LEN` shifts.
- R8: `pads_hiz` is high exactly while the applied instruction is 000 or 010. It changes only on Update-IR or in Test-Logic-Reset.
- R9: `tdo` and `tdo_oe` are updated on the falling edge of `tck`, so `tdo` holds its value across the rising edge. `tdo_oe` is high only when the controller is in Shift-IR or Shift-DR.
- R10: With `rst` high, the controller enters Test-Logic-Reset with the identification instruction applied, and `tdo_oe` and `pads_hiz` low. A data scan right after reset returns the identification word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Chip-level synchronous reset, active high |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| pad_sample | input | BSR_LEN | Parallel pad values sampled by the boundary register |
| tdo | output | 1 | Serial test data out, changes on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo`, high during shift states |
| pads_hiz | output | 1 | Request to float all data drivers |

## Verification
On every cycle, the assertions check:
- the forced path into Test-Logic-Reset and the key state transitions;
- that the applied instruction and `pads_hiz` hold outside Update-IR and reset;
- that the bypass and placeholder cells capture zero;
- that `tdo_oe` is confined to the shift states.

Only the bench's scenarios can show the following:
- the full decode of all eight codes;
- the exact identification and boundary contents and their bit order;
- the register lengths seen through the serial path;
- a scan resumed across Pause-DR;
- that `tdo` holds across the rising edge.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

  localparam int TAP_IR_W = 3;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BSR} dr_sel_e;

  localparam logic [TAP_IR_W-1:0] OP_SAMPLEZ_A = 3'b000;
  localparam logic [TAP_IR_W-1:0] OP_IDCODE    = 3'b001;
  localparam logic [TAP_IR_W-1:0] OP_SAMPLEZ_B = 3'b010;
  localparam logic [TAP_IR_W-1:0] OP_SAMPLE    = 3'b100;
  localparam logic [TAP_IR_W-1:0] IR_CAPTURE   = 3'b001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    tap_state_e n;
    case (s)
      ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
      default:   n = ST_TLR;
    endcase
    return n;
  endfunction

  function automatic dr_sel_e op_dr_sel(input logic [TAP_IR_W-1:0] op);
    dr_sel_e r;
    case (op)
      OP_IDCODE:                            r = DR_ID;
      OP_SAMPLEZ_A, OP_SAMPLEZ_B, OP_SAMPLE: r = DR_BSR;
      default:                              r = DR_BYP;
    endcase
    return r;
  endfunction

  function automatic logic op_hiz(input logic [TAP_IR_W-1:0] op);
    return (op == OP_SAMPLEZ_A) || (op == OP_SAMPLEZ_B);
  endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm import tap_pkg::*; (
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck) begin
    if (rst) state <= ST_TLR;
    else     state <= tap_next(state, tms);
  end

  // Run of consecutive high tms samples, saturating at five
  logic [2:0] ones_run;
  always_ff @(posedge tck) begin
    if (rst)           ones_run <= 3'd0;
    else if (!tms)     ones_run <= 3'd0;
    else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
  end

  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (rst)
    (ones_run == 3'd5) |-> (state == ST_TLR));

  a_r1_tlr_hold: assert property (@(posedge tck) disable iff (rst)
    (state == ST_TLR && tms) |=> (state == ST_TLR));

  a_r1_sel_ir_escape: assert property (@(posedge tck) disable iff (rst)
    (state == ST_SEL_IR && tms) |=> (state == ST_TLR));

  a_r1_update_to_idle: assert property (@(posedge tck) disable iff (rst)
    ((state == ST_UPD_DR || state == ST_UPD_IR) && !tms) |=> (state == ST_RTI));

  a_r1_shift_dr_stay: assert property (@(posedge tck) disable iff (rst)
    (state == ST_SHF_DR && !tms) |=> (state == ST_SHF_DR));

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir import tap_pkg::*; (
  input  logic       tck,
  input  logic       rst,
  input  logic       tdi,
  input  tap_state_e state,
  output logic       ir_lsb,
  output dr_sel_e    dr_sel,
  output logic       pads_hiz
);

  logic [TAP_IR_W-1:0] ir_sh;
  logic [TAP_IR_W-1:0] ir_act;

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sh    <= IR_CAPTURE;
      ir_act   <= OP_IDCODE;
      dr_sel   <= DR_ID;
      pads_hiz <= 1'b0;
    end else begin
      case (state)
        ST_TLR: begin
          ir_sh    <= IR_CAPTURE;
          ir_act   <= OP_IDCODE;
          dr_sel   <= DR_ID;
          pads_hiz <= 1'b0;
        end
        ST_CAP_IR: ir_sh <= IR_CAPTURE;
        ST_SHF_IR: ir_sh <= {tdi, ir_sh[TAP_IR_W-1:1]};
        ST_UPD_IR: begin
          ir_act   <= ir_sh;
          dr_sel   <= op_dr_sel(ir_sh);
          pads_hiz <= op_hiz(ir_sh);
        end
        default: ;
      endcase
    end
  end

  assign ir_lsb = ir_sh[0];

  a_r10_tlr_loads_idcode: assert property (@(posedge tck) disable iff (rst)
    (state == ST_TLR) |=> (ir_act == OP_IDCODE && !pads_hiz && dr_sel == DR_ID));

  a_r8_instr_stable: assert property (@(posedge tck) disable iff (rst)
    (state != ST_UPD_IR && state != ST_TLR) |=> ($stable(ir_act) && $stable(pads_hiz)));

  a_r3_capture_pattern: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_IR) |=> (ir_sh == 3'b001));

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr import tap_pkg::*; #(
  parameter int                 BSR_LEN   = 70,
  parameter logic [BSR_LEN-1:0] PH_MASK   = '0,
  parameter logic [3:0]         ID_REV    = 4'b0000,
  parameter logic [9:0]         ID_PART   = 10'b0100000100,
  parameter logic [5:0]         ID_VDEF   = 6'b000000,
  parameter logic [10:0]        ID_VENDOR = 11'b00000000111
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               tdi,
  input  tap_state_e         state,
  input  dr_sel_e            dr_sel,
  input  logic [BSR_LEN-1:0] pad_sample,
  output logic               dr_lsb
);

  localparam int          ID_W    = 32;
  localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_PART, ID_VDEF, ID_VENDOR, 1'b1};

  logic               byp_q;
  logic [ID_W-1:0]    id_q;
  logic [BSR_LEN-1:0] bsr_q;

  wire capture = (state == ST_CAP_DR);
  wire shift   = (state == ST_SHF_DR);

  always_ff @(posedge tck) begin
    if (rst) begin
      byp_q <= 1'b0;
      id_q  <= '0;
      bsr_q <= '0;
    end else begin
      case (dr_sel)
        DR_BYP: begin
          if (capture)    byp_q <= 1'b0;
          else if (shift) byp_q <= tdi;
        end
        DR_ID: begin
          if (capture)    id_q <= ID_WORD;
          else if (shift) id_q <= {tdi, id_q[ID_W-1:1]};
        end
        DR_BSR: begin
          if (capture)    bsr_q <= pad_sample & ~PH_MASK;
          else if (shift) bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (dr_sel)
      DR_ID:   dr_lsb = id_q[0];
      DR_BSR:  dr_lsb = bsr_q[0];
      default: dr_lsb = byp_q;
    endcase
  end

  a_r6_bypass_zero: assert property (@(posedge tck) disable iff (rst)
    (capture && dr_sel == DR_BYP) |=> (byp_q == 1'b0));

  a_r7_placeholder_zero: assert property (@(posedge tck) disable iff (rst)
    (capture && dr_sel == DR_BSR) |=> ((bsr_q & PH_MASK) == '0));

  a_r5_id_start_bit: assert property (@(posedge tck) disable iff (rst)
    (capture && dr_sel == DR_ID) |=> (id_q[0] == 1'b1));

endmodule

// File: rtl/tap_lite.sv
`timescale 1ns/1ps
module tap_lite import tap_pkg::*; #(
  parameter int                 BSR_LEN   = 70,
  parameter logic [BSR_LEN-1:0] PH_MASK   = {{(BSR_LEN-1){1'b0}}, 1'b1} << (BSR_LEN/2),
  parameter logic [3:0]         ID_REV    = 4'b0000,
  parameter logic [9:0]         ID_PART   = 10'b0100000100,
  parameter logic [5:0]         ID_VDEF   = 6'b000000,
  parameter logic [10:0]        ID_VENDOR = 11'b00000000111
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pad_sample,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               pads_hiz
);

  tap_state_e state;
  dr_sel_e    dr_sel;
  logic       ir_lsb;
  logic       dr_lsb;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state)
  );

  tap_ir u_ir (
    .tck      (tck),
    .rst      (rst),
    .tdi      (tdi),
    .state    (state),
    .ir_lsb   (ir_lsb),
    .dr_sel   (dr_sel),
    .pads_hiz (pads_hiz)
  );

  tap_dr #(
    .BSR_LEN   (BSR_LEN),
    .PH_MASK   (PH_MASK),
    .ID_REV    (ID_REV),
    .ID_PART   (ID_PART),
    .ID_VDEF   (ID_VDEF),
    .ID_VENDOR (ID_VENDOR)
  ) u_dr (
    .tck        (tck),
    .rst        (rst),
    .tdi        (tdi),
    .state      (state),
    .dr_sel     (dr_sel),
    .pad_sample (pad_sample),
    .dr_lsb     (dr_lsb)
  );

  // Serial output launched on the falling edge
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
      if (state == ST_SHF_IR)      tdo <= ir_lsb;
      else if (state == ST_SHF_DR) tdo <= dr_lsb;
      else                         tdo <= 1'b0;
    end
  end

  a_r9_oe_only_in_shift: assert property (@(posedge tck) disable iff (rst)
    tdo_oe |-> (state == ST_SHF_IR || state == ST_SHF_DR));

  a_r9_oe_in_shift: assert property (@(posedge tck) disable iff (rst)
    ($past(state) == ST_SHF_DR && state == ST_SHF_DR) |-> tdo_oe);

endmodule

// File: tb/test_tap_lite.sv
`timescale 1ns/1ps
module test_tap_lite;

  localparam int               BSR_LEN = 70;
  localparam logic [69:0]      PH_MASK = (70'd1 << 41) | (70'd1 << 3);
  localparam logic [5:0]       VDEF    = 6'b101101;
  localparam logic [31:0]      ID_EXP  = {4'b0000, 10'b0100000100, VDEF, 11'b00000000111, 1'b1};
  localparam logic [69:0]      PADS    = {6'b101101, 64'hDEAD_BEEF_1234_5678};
  localparam logic [79:0]      PAT     = 80'hC3A5_9F01_7E24_B6D8_1F2E;

  // {code[5:3], kind[2:1] (0 bypass, 1 id, 2 boundary), hiz[0]}
  localparam logic [5:0] VEC [8] = '{
    6'b000_10_1, 6'b001_01_0, 6'b010_10_1, 6'b011_00_0,
    6'b100_10_0, 6'b101_00_0, 6'b110_00_0, 6'b111_00_0
  };

  logic tck = 1'b0;
  logic rst = 1'b1;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_oe, pads_hiz;

  int nvec  = 0;
  int nfail = 0;

  always #2 tck = ~tck;

  tap_lite #(.BSR_LEN(BSR_LEN), .PH_MASK(PH_MASK), .ID_VDEF(VDEF)) i_tap_lite (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .pad_sample(PADS),
    .tdo(tdo), .tdo_oe(tdo_oe), .pads_hiz(pads_hiz)
  );

  task automatic check(input string req, input logic [79:0] got, input logic [79:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic so, output logic soe);
    @(negedge tck); #1;
    tms = m; tdi = d;
    so = tdo; soe = tdo_oe;
    @(posedge tck);
  endtask

  task automatic step(input logic m);
    logic a, b;
    tick(m, 1'b0, a, b);
  endtask

  task automatic peek(output logic so, output logic soe, output logic hz);
    @(negedge tck); #1;
    so = tdo; soe = tdo_oe; hz = pads_hiz;
  endtask

  // From Run-Test/Idle back to Run-Test/Idle
  task automatic load_ir(input logic [2:0] code, output logic [2:0] seen);
    logic o;
    step(1); step(1); step(0); step(0);
    for (int i = 0; i < 3; i++) tick(i == 2, code[i], seen[i], o);
    step(1); step(0);
  endtask

  task automatic scan_dr(input int n, output logic [79:0] seen, output logic oe0);
    logic o;
    seen = '0;
    step(1); step(0); step(0);
    for (int i = 0; i < n; i++) begin
      tick(i == n-1, PAT[i], seen[i], o);
      if (i == 0) oe0 = o;
    end
    step(1); step(0);
  endtask

  function automatic logic [79:0] expect_scan(input int len, input logic [79:0] cap);
    logic [79:0] r;
    for (int i = 0; i < 80; i++) r[i] = (i < len) ? cap[i] : PAT[i-len];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge tck);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [79:0] got;
    logic [2:0]  irs;
    logic        so, soe, hz, oe0, a, b;
    int          len;
    logic [79:0] cap;

    repeat (4) @(posedge tck);
    #1 rst = 1'b0;

    // R10 reset state
    peek(so, soe, hz);
    check("R10 oe after reset", {79'd0, soe}, 80'd0);
    check("R10 hiz after reset", {79'd0, hz}, 80'd0);
    step(0);
    scan_dr(80, got, oe0);
    check("R10 id after reset", got, expect_scan(32, {48'd0, ID_EXP}));

    // Vector table: every instruction code
    for (int v = 0; v < 8; v++) begin
      load_ir(VEC[v][5:3], irs);
      check("R3 capture-ir", {77'd0, irs}, 80'd1);
      peek(so, soe, hz);
      check("R8 hiz for code", {79'd0, hz}, {79'd0, VEC[v][0]});
      check("R9 oe idle", {79'd0, soe}, 80'd0);
      scan_dr(80, got, oe0);
      check("R9 oe shift", {79'd0, oe0}, 80'd1);
      case (VEC[v][2:1])
        2'd1:    begin len = 32;      cap = {48'd0, ID_EXP}; end
        2'd2:    begin len = BSR_LEN; cap = {10'd0, PADS & ~PH_MASK}; end
        default: begin len = 1;       cap = '0; end
      endcase
      // R4 selection, R5 id word, R6 bypass, R7 boundary
      check("R4 R5 R6 R7 scan", got, expect_scan(len, cap));
    end

    // R1: ID scan split by Pause-DR, resumed without recapture
    load_ir(3'b001, irs);
    step(1); step(0); step(0);
    got = '0;
    for (int i = 0; i < 16; i++) tick(i == 15, 1'b0, got[i], a);
    step(0);
    tick(0, 1'b0, a, b);
    check("R9 oe in pause", {79'd0, b}, 80'd0);
    step(1); step(0);
    for (int i = 16; i < 32; i++) tick(i == 31, 1'b0, got[i], a);
    step(1); step(0);
    check("R1 pause resume", got, {48'd0, ID_EXP});

    // R9: tdo holds across the rising edge during shift
    step(1); step(0); step(0);
    @(negedge tck); #1; tms = 0; tdi = 0; a = tdo;
    @(posedge tck); #0.5; b = tdo;
    check("R9 tdo hold", {79'd0, b}, {79'd0, a});
    check("R9 tdo first bit", {79'd0, a}, {79'd0, ID_EXP[0]});

    // R2: five ones from mid Shift-DR with SAMPLE-Z applied
    for (int i = 0; i < 5; i++) step(1);
    step(0);
    load_ir(3'b010, irs);
    peek(so, soe, hz);
    check("R8 hiz set", {79'd0, hz}, 80'd1);
    step(1); step(0); step(0);
    for (int i = 0; i < 5; i++) step(1);
    step(0);
    peek(so, soe, hz);
    check("R2 hiz cleared", {79'd0, hz}, 80'd0);
    scan_dr(80, got, oe0);
    check("R2 idcode after forced reset", got, expect_scan(32, {48'd0, ID_EXP}));

    // R2: five ones from Pause-IR
    load_ir(3'b011, irs);
    step(1); step(1); step(0); step(1); step(0);
    for (int i = 0; i < 5; i++) step(1);
    step(0);
    scan_dr(80, got, oe0);
    check("R2 from pause-ir", got, expect_scan(32, {48'd0, ID_EXP}));

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule